// File: doc/BRIEF.md
# Transmit Clip and 6-bit Quantiser

This block sits between the transmit inverse transform and a 6-bit digital-to-analogue converter. It takes real time-domain samples and limits each one to a symmetric window set at run time. It then multiplies the limited value by a programmable gain and divides it by a programmable power of two. The result is rounded to the nearest integer, with ties going to the even neighbour, and saturated to a signed 6-bit range. An offset of 32 is added, so a zero sample leaves at mid-scale.

Several lanes arrive together in each beat under one valid flag, and every lane is updated in the same cycle. The clip window is usually tuned so that the gain and shift place the window edge at full scale. The window is adjusted to trade clipping noise against quantisation noise. A saturating counter reports how many samples were limited since the last frame start.

Top module: `tx_clip_quant`

## Requirements
- R1: After reset, `out_valid` is 0 and `clip_count` is 0.
- R2: `out_valid` is `in_valid` delayed by one clock. `out_codes` and `clip_count` change only in the cycle after a beat with `in_valid` high, and otherwise hold their values.
- R3: A sample x (two's complement, `IN_W` bits) is replaced by +L when x > L and by −L when x < −L, where L is the unsigned `clip_level`. Samples with |x| ≤ L, including x = ±L exactly, pass unchanged. The most negative input is limited to −L.
- R4: The limited value c gives v = c·gain / 2^shift, rounded to the nearest integer with exact halves going to the even integer. When shift is 0, v = c·gain. When gain is 0, v is 0.
- R5: v is saturated to the range −32 to +31.
- R6: The output code is v + 32 as a 6-bit unsigned number, so v = 0 gives code 32, −32 gives 0 and +31 gives 63.
- R7: Lane i takes its sample from `in_samples[i*IN_W +: IN_W]` and drives `out_codes[i*6 +: 6]`. Each lane is computed independently of the others.
- R8: For each valid beat, `clip_count` adds the number of lanes that were limited (|x| > L). A beat with `frame_start` high restarts the count from that beat's own number of limited lanes. The count saturates at 2^CNT_W − 1.
- R9: A sample exactly at ±L is not counted as limited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat of samples present |
| frame_start | input | 1 | Restart the clip count with this beat |
| in_samples | input | LANES*IN_W | Signed samples, lane 0 in the low bits |
| clip_level | input | IN_W-1 | Unsigned clip magnitude |
| gain | input | GAIN_W | Unsigned scale multiplier |
| shift | input | SHIFT_W | Right shift applied after the multiply |
| out_valid | output | 1 | Codes valid |
| out_codes | output | LANES*6 | Offset-binary DAC codes, lane 0 in the low bits |
| clip_count | output | CNT_W | Saturating count of limited samples in the frame |

## Verification
The properties assume that `in_valid`, `frame_start` and the configuration inputs are known on every clock edge after reset. They also assume that `frame_start` only matters together with `in_valid`. The zero-gain property relies on `gain` being sampled with the same beat as the samples. The stimulus drives every input on the falling edge from a single process and holds reset low for several cycles. It changes configuration only together with a beat, so the limiter, scaler and count always see consistent values.

// File: rtl/tx_cq_pkg.sv
package tx_cq_pkg;
   typedef enum logic [1:0] {
      CLIP_NONE = 2'd0,
      CLIP_HIGH = 2'd1,
      CLIP_LOW  = 2'd2
   } clip_kind_e;
endpackage

// File: rtl/tx_cq_limiter.sv
module tx_cq_limiter
   import tx_cq_pkg::*;
#(
   parameter int IN_W = 12
) (
   input  logic signed [IN_W-1:0] smp,
   input  logic        [IN_W-2:0] level,
   output logic signed [IN_W-1:0] lim,
   output clip_kind_e             kind
);
   logic signed [IN_W-1:0] pos_edge;
   logic signed [IN_W-1:0] neg_edge;

   always_comb begin
      pos_edge = $signed({1'b0, level});
      neg_edge = -pos_edge;
      if (smp > pos_edge) begin
         lim  = pos_edge;
         kind = CLIP_HIGH;
      end else if (smp < neg_edge) begin
         lim  = neg_edge;
         kind = CLIP_LOW;
      end else begin
         lim  = smp;
         kind = CLIP_NONE;
      end
   end
endmodule

// File: rtl/tx_cq_scaler.sv
module tx_cq_scaler #(
   parameter int IN_W    = 12,
   parameter int GAIN_W  = 8,
   parameter int SHIFT_W = 4,
   parameter int OUT_W   = 6
) (
   input  logic signed [IN_W-1:0]    lim,
   input  logic        [GAIN_W-1:0]  gain,
   input  logic        [SHIFT_W-1:0] shift,
   output logic        [OUT_W-1:0]   code
);
   localparam int PW = IN_W + GAIN_W + 1;
   localparam int RW = PW + 1;
   localparam logic signed [RW-1:0] HI = RW'((2 ** (OUT_W - 1)) - 1);
   localparam logic signed [RW-1:0] LO = -HI - RW'(1);

   logic signed [PW-1:0] lim_x, gain_x, prod, floor_q;
   logic        [PW-1:0] unit, mask, rem, half;
   logic                 bump;
   logic signed [RW-1:0] rounded;
   logic signed [OUT_W-1:0] val;

   always_comb begin
      lim_x   = PW'(lim);
      gain_x  = $signed(PW'({1'b0, gain}));
      prod    = lim_x * gain_x;
      floor_q = prod >>> shift;
      unit    = PW'(1) << shift;
      mask    = unit - PW'(1);
      rem     = prod & mask;
      half    = unit >> 1;
      bump    = (shift != '0) && ((rem > half) || ((rem == half) && floor_q[0]));
      rounded = {floor_q[PW-1], floor_q} + RW'(bump);
      if (rounded > HI)      val = HI[OUT_W-1:0];
      else if (rounded < LO) val = LO[OUT_W-1:0];
      else                   val = rounded[OUT_W-1:0];
      code = {~val[OUT_W-1], val[OUT_W-2:0]};
   end
endmodule

// File: rtl/tx_cq_tally.sv
module tx_cq_tally #(
   parameter int LANES = 4,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             frame_start,
   input  logic [LANES-1:0] hits,
   output logic [CNT_W-1:0] count
);
   localparam int PCW = $clog2(LANES + 1);
   localparam logic [CNT_W:0] TOP = {1'b0, {CNT_W{1'b1}}};

   logic [PCW-1:0]   pop;
   logic [CNT_W-1:0] base;
   logic [CNT_W:0]   sum;

   always_comb begin
      pop = '0;
      for (int i = 0; i < LANES; i++) pop = pop + PCW'(hits[i]);
      base = frame_start ? '0 : count;
      sum  = {1'b0, base} + (CNT_W + 1)'(pop);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        count <= '0;
      else if (in_valid) count <= (sum > TOP) ? TOP[CNT_W-1:0] : sum[CNT_W-1:0];
   end
endmodule

// File: rtl/tx_clip_quant.sv
module tx_clip_quant
   import tx_cq_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int IN_W    = 12,
   parameter int GAIN_W  = 8,
   parameter int SHIFT_W = 4,
   parameter int CNT_W   = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  frame_start,
   input  logic [LANES*IN_W-1:0] in_samples,
   input  logic [IN_W-2:0]       clip_level,
   input  logic [GAIN_W-1:0]     gain,
   input  logic [SHIFT_W-1:0]    shift,
   output logic                  out_valid,
   output logic [LANES*6-1:0]    out_codes,
   output logic [CNT_W-1:0]      clip_count
);
   localparam int OUT_W = 6;
   localparam int PW    = IN_W + GAIN_W + 1;

   if (LANES < 1) begin : g_bad_lanes
      $error("tx_clip_quant: LANES must be at least 1");
   end
   if (IN_W < 3) begin : g_bad_in_w
      $error("tx_clip_quant: IN_W must be at least 3");
   end
   if ((2 ** SHIFT_W) > PW) begin : g_bad_shift
      $error("tx_clip_quant: shift range exceeds product width");
   end
   if (CNT_W < $clog2(LANES + 1)) begin : g_bad_cnt
      $error("tx_clip_quant: CNT_W too narrow for one beat");
   end

   logic [LANES-1:0]       hits;
   logic [LANES*OUT_W-1:0] codes_d;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic signed [IN_W-1:0] lim;
      clip_kind_e             kind;

      tx_cq_limiter #(.IN_W(IN_W)) u_lim (
         .smp   ($signed(in_samples[i*IN_W +: IN_W])),
         .level (clip_level),
         .lim   (lim),
         .kind  (kind)
      );

      tx_cq_scaler #(
         .IN_W(IN_W), .GAIN_W(GAIN_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)
      ) u_scl (
         .lim   (lim),
         .gain  (gain),
         .shift (shift),
         .code  (codes_d[i*OUT_W +: OUT_W])
      );

      assign hits[i] = (kind != CLIP_NONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_codes <= {LANES{6'd32}};
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_codes <= codes_d;
      end
   end

   tx_cq_tally #(.LANES(LANES), .CNT_W(CNT_W)) u_tally (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .frame_start (frame_start),
      .hits        (hits),
      .count       (clip_count)
   );
endmodule

// File: rtl/tx_clip_quant_chk.sv
module tx_clip_quant_chk #(
   parameter int LANES   = 4,
   parameter int IN_W    = 12,
   parameter int GAIN_W  = 8,
   parameter int SHIFT_W = 4,
   parameter int CNT_W   = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic                  frame_start,
   input logic [GAIN_W-1:0]     gain,
   input logic                  out_valid,
   input logic [LANES*6-1:0]    out_codes,
   input logic [CNT_W-1:0]      clip_count
);
   assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)));

   assert_codes_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(in_valid)) |-> $stable(out_codes));

   assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(in_valid)) |-> $stable(clip_count));

   assert_count_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && !$past(frame_start))
         |-> ((clip_count >= $past(clip_count))
              && ((clip_count - $past(clip_count)) <= CNT_W'(LANES))));

   assert_restart_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && $past(frame_start))
         |-> (clip_count <= CNT_W'(LANES)));

   for (genvar i = 0; i < LANES; i++) begin : g_zero
      assert_zero_gain_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(in_valid) && ($past(gain) == '0))
            |-> (out_codes[i*6 +: 6] == 6'd32));
   end
endmodule

bind tx_clip_quant tx_clip_quant_chk #(
   .LANES(LANES), .IN_W(IN_W), .GAIN_W(GAIN_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .frame_start (frame_start),
   .gain        (gain),
   .out_valid   (out_valid),
   .out_codes   (out_codes),
   .clip_count  (clip_count)
);

// File: tb/tx_clip_quant_tb.sv
module tx_clip_quant_tb;
   localparam int LANES   = 4;
   localparam int IN_W    = 12;
   localparam int GAIN_W  = 8;
   localparam int SHIFT_W = 4;
   localparam int CNT_W   = 5;
   localparam int CMAX    = (1 << CNT_W) - 1;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  in_valid = 1'b0;
   logic                  frame_start = 1'b0;
   logic [LANES*IN_W-1:0] in_samples = '0;
   logic [IN_W-2:0]       clip_level = '0;
   logic [GAIN_W-1:0]     gain = '0;
   logic [SHIFT_W-1:0]    shift = '0;
   logic                  out_valid;
   logic [LANES*6-1:0]    out_codes;
   logic [CNT_W-1:0]      clip_count;

   int total = 0;
   int bad = 0;
   int mdl_cnt = 0;
   bit done = 1'b0;

   logic [LANES*6-1:0] q_codes[$];
   int                 q_cnt[$];
   string              q_tag[$];

   always #5 clk = ~clk;

   tx_clip_quant #(
      .LANES(LANES), .IN_W(IN_W), .GAIN_W(GAIN_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_start(frame_start),
      .in_samples(in_samples), .clip_level(clip_level), .gain(gain), .shift(shift),
      .out_valid(out_valid), .out_codes(out_codes), .clip_count(clip_count)
   );

   function automatic int model_code(input int x, input int lvl, input int g,
                                     input int s, output bit hit);
      longint c, p, q, rem, half;
      c = x; hit = 1'b0;
      if (x > lvl) begin c = lvl; hit = 1'b1; end
      else if (x < -lvl) begin c = -lvl; hit = 1'b1; end
      p = c * g;
      q = p >>> s;
      rem = p - (q <<< s);
      half = (s == 0) ? 0 : (longint'(1) <<< (s - 1));
      if (s != 0 && (rem > half || (rem == half && q[0]))) q = q + 1;
      if (q > 31) q = 31;
      if (q < -32) q = -32;
      return int'(q) + 32;
   endfunction

   task automatic check(input string tag, input bit ok, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic beat(input string tag, input int xs[LANES], input int lvl,
                       input int g, input int s, input bit fs);
      logic [LANES*6-1:0] exp;
      int hits;
      bit h;
      @(negedge clk);
      hits = 0;
      for (int i = 0; i < LANES; i++) begin
         in_samples[i*IN_W +: IN_W] = IN_W'(xs[i]);
         exp[i*6 +: 6] = 6'(model_code(xs[i], lvl, g, s, h));
         hits += int'(h);
      end
      clip_level = (IN_W-1)'(lvl);
      gain = GAIN_W'(g);
      shift = SHIFT_W'(s);
      frame_start = fs;
      in_valid = 1'b1;
      if (fs) mdl_cnt = 0;
      mdl_cnt = (mdl_cnt + hits > CMAX) ? CMAX : mdl_cnt + hits;
      q_codes.push_back(exp);
      q_cnt.push_back(mdl_cnt);
      q_tag.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      frame_start = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q_codes.size() == 0) begin
            check("R2 unexpected out_valid", 1'b0, 1, 0);
         end else begin
            logic [LANES*6-1:0] e;
            int ec;
            string t;
            e = q_codes.pop_front();
            ec = q_cnt.pop_front();
            t = q_tag.pop_front();
            for (int i = 0; i < LANES; i++)
               check({t, " R7 lane code"}, out_codes[i*6 +: 6] == e[i*6 +: 6],
                     out_codes[i*6 +: 6], e[i*6 +: 6]);
            check({t, " R8 clip_count"}, int'(clip_count) == ec, clip_count, ec);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [LANES*6-1:0] held;
      logic [CNT_W-1:0]   held_cnt;
      int xs[LANES];
      repeat (4) @(negedge clk);
      check("R1 out_valid after reset", out_valid == 1'b0, out_valid, 0);
      check("R1 clip_count after reset", clip_count == '0, clip_count, 0);
      rst_n = 1'b1;

      // R3 / R9: exact threshold passes uncounted, one past it is limited
      beat("R3 R9 threshold", '{100, -100, 101, -101}, 100, 1, 2, 1'b1);
      beat("R3 extremes", '{-2048, 2047, 0, 50}, 2047, 1, 6, 1'b0);
      // R4: ties to even
      beat("R4 ties", '{1, 3, -1, -3}, 2047, 1, 1, 1'b1);
      beat("R4 ties b", '{5, 7, -5, -7}, 2047, 1, 1, 1'b0);
      beat("R4 shift zero", '{7, -9, 0, 13}, 2047, 2, 0, 1'b0);
      beat("R4 zero gain", '{500, -500, 17, -2048}, 2047, 0, 3, 1'b0);
      // R5 / R6: saturation and offset
      beat("R5 R6 saturate", '{100, -100, 0, 1}, 2047, 255, 0, 1'b0);
      beat("R6 full scale edges", '{31, -32, 0, -1}, 2047, 1, 0, 1'b0);
      // R7: distinct lanes
      beat("R7 lanes", '{256, -512, 1024, -64}, 2047, 1, 5, 1'b0);
      idle();

      // R2: hold while idle
      @(negedge clk);
      held = out_codes;
      held_cnt = clip_count;
      repeat (3) @(negedge clk);
      check("R2 out_valid low while idle", out_valid == 1'b0, out_valid, 0);
      check("R2 codes hold while idle", out_codes == held, out_codes, held);
      check("R2 count holds while idle", clip_count == held_cnt, clip_count, held_cnt);

      // R8: saturation of count, then restart
      beat("R8 sat start", '{9, -9, 9, -9}, 0, 1, 0, 1'b1);
      for (int k = 0; k < 10; k++) beat("R8 sat", '{3, -3, 1, -1}, 0, 1, 0, 1'b0);
      beat("R8 restart", '{10, 0, 0, 0}, 5, 3, 1, 1'b1);
      beat("R8 accumulate", '{-10, 4, 0, 6}, 5, 3, 1, 1'b0);

      // mixed stimulus
      for (int k = 0; k < 400; k++) begin
         for (int i = 0; i < LANES; i++) xs[i] = int'($urandom_range(4095)) - 2048;
         beat("R3 R4 R5 mix", xs, int'($urandom_range(2047)), int'($urandom_range(255)),
              int'($urandom_range(15)), ($urandom_range(15) == 0));
         if ($urandom_range(5) == 0) idle();
      end
      idle();
      repeat (3) @(negedge clk);
      check("R2 all results drained", q_codes.size() == 0, q_codes.size(), 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule